// File: doc/BRIEF.md
# Triggered Programmable-Width One-Shot

This block produces one clean pulse per trigger. When the trigger input is seen going from low to high at a clock edge and the block is idle, a pulse starts on `pulse_out`. The pulse lasts a fixed inherent number of clock cycles plus the value of a width code. `pulse_out_n` always carries the inverse of `pulse_out`.

The width code has two parts. The low `FINE_W` bits form a fine field, counted one cycle per step. The high `COARSE_W` bits form a coarse field, counted in units of 2^FINE_W cycles once the fine count has run out. A mode input can set the fine field aside, so the block becomes a coarse-only generator whose step is 2^FINE_W cycles.

While a pulse is running, new trigger edges are ignored. After the pulse ends, there is a recovery interval of `RECOV` cycles during which triggers are also ignored. A kill input cuts a pulse short and holds the block idle. The same recovery interval then applies after the kill is released.

Top module: `oneshot_gen`

## Requirements
- R1: A trigger edge (trig high at a clock edge, low at the one before) accepted while the block is idle sets `pulse_out` high right after that same clock edge.
- R2: `pulse_out_n` equals the inverse of `pulse_out` at all times.
- R3: With `coarse_only` low, `pulse_out` stays high for exactly INH + width_code clock cycles, where width_code[FINE_W-1:0] is the fine field and the remaining upper bits are the coarse field.
- R4: A width code of zero gives a pulse of exactly INH cycles.
- R5: With `coarse_only` high at the trigger, the width is INH + 2^FINE_W × width_code[FINE_W+COARSE_W-1:FINE_W], whatever the fine bits hold.
- R6: Trigger edges that occur while `pulse_out` is high have no effect on that pulse's length.
- R7: The width code and mode are captured at the accepted trigger edge. Changing them during a pulse does not change that pulse.
- R8: Let E be the clock edge at which `pulse_out` falls. A trigger edge at clock edge E+k is ignored for k ≤ RECOV and accepted for k = RECOV+1.
- R9: `kill` high at a clock edge forces `pulse_out` low after that edge and keeps it low while `kill` stays high, with trigger edges ignored. Taking the last kill-high edge as E, the R8 recovery timing applies.
- R10: The largest code (all ones) gives INH + 2^(FINE_W+COARSE_W) − 1 cycles, with the fine count followed by every coarse unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; block idle, output low |
| trig | input | 1 | Trigger; rising edge starts a pulse |
| kill | input | 1 | Ends any pulse and holds the block idle |
| coarse_only | input | 1 | When high, the fine field is treated as zero |
| width_code | input | FINE_W+COARSE_W | Width code: fine field in the low bits, coarse above |
| pulse_out | output | 1 | Pulse output |
| pulse_out_n | output | 1 | Inverse of pulse_out |

## Verification
The bench builds the block with FINE_W=6, COARSE_W=5, INH=3 and RECOV=2. This shrinks the all-ones code to a pulse of about two thousand cycles, so the maximum code and crossings of many coarse units are measured in full. A non-default inherent width and a recovery interval of more than one cycle show that both parameters are honoured. The recovery boundary is probed on both sides, after a normal end and after a kill.

// File: rtl/oneshot_gen.sv
module oneshot_gen #(
  parameter int FINE_W   = 6,
  parameter int COARSE_W = 16,
  parameter int INH      = 2,
  parameter int RECOV    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig,
  input  logic                       kill,
  input  logic                       coarse_only,
  input  logic [FINE_W+COARSE_W-1:0] width_code,
  output logic                       pulse_out,
  output logic                       pulse_out_n
);
  localparam int CODE_W = FINE_W + COARSE_W;
  localparam int IW     = $clog2(INH + 1);
  localparam int RW     = $clog2(RECOV + 1);

  logic                active, trig_q;
  logic [IW-1:0]       inh_left;
  logic [FINE_W-1:0]   fine_left, sub_left;
  logic [COARSE_W-1:0] coarse_left;
  logic [RW-1:0]       recov_left;

  wire trig_edge = trig & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      trig_q      <= 1'b0;
      inh_left    <= '0;
      fine_left   <= '0;
      sub_left    <= '0;
      coarse_left <= '0;
      recov_left  <= '0;
    end else begin
      trig_q <= trig;
      if (kill) begin
        active     <= 1'b0;
        recov_left <= RW'(RECOV);
      end else if (active) begin
        if (inh_left != '0)
          inh_left <= inh_left - 1'b1;
        else if (fine_left != '0)
          fine_left <= fine_left - 1'b1;
        else if (coarse_left != '0) begin
          if (sub_left == '0) begin
            coarse_left <= coarse_left - 1'b1;
            sub_left    <= '1;
          end else
            sub_left <= sub_left - 1'b1;
        end else begin
          active     <= 1'b0;
          recov_left <= RW'(RECOV);
        end
      end else if (recov_left != '0)
        recov_left <= recov_left - 1'b1;
      else if (trig_edge) begin
        active      <= 1'b1;
        inh_left    <= IW'(INH - 1);
        fine_left   <= coarse_only ? '0 : width_code[FINE_W-1:0];
        coarse_left <= width_code[CODE_W-1:FINE_W];
        sub_left    <= '1;
      end
    end
  end

  assign pulse_out   = active;
  assign pulse_out_n = ~active;
endmodule

// File: rtl/oneshot_gen_chk.sv
module oneshot_gen_chk #(
  parameter int INH = 2
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic kill,
  input logic pulse_out,
  input logic pulse_out_n
);
  assert_start_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> ($past(trig) && !$past(trig, 2)));

  assert_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(pulse_out) |-> $changed(pulse_out_n));

  assert_kill_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !pulse_out);

  assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |=> !pulse_out);

  if (INH >= 2) begin : g_min
    assert_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pulse_out) && !kill) |=> pulse_out);
  end
endmodule

bind oneshot_gen oneshot_gen_chk #(.INH(INH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .kill(kill),
  .pulse_out(pulse_out), .pulse_out_n(pulse_out_n)
);

// File: tb/oneshot_gen_test.sv
`timescale 1ns/1ps
module oneshot_gen_test;
  localparam int FW = 6, CW = 5, INH = 3, RECOV = 2;
  localparam int NW = FW + CW;

  logic clk = 0, rst_n = 0, trig = 0, kill = 0, co = 0;
  logic [NW-1:0] code = '0;
  wire pout, pout_n;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  oneshot_gen #(.FINE_W(FW), .COARSE_W(CW), .INH(INH), .RECOV(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .kill(kill), .coarse_only(co),
    .width_code(code), .pulse_out(pout), .pulse_out_n(pout_n));

  function automatic int exp_w(int c, bit m);
    return INH + (m ? (c & ~((1 << FW) - 1)) : c);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Starts a pulse, measures its length; returns at the first negedge with output low.
  task automatic fire(int c, bit m, bit disturb, output int w);
    @(negedge clk); code = NW'(c); co = m; trig = 1;
    @(negedge clk);
    check(pout == 1, "R1", pout, 1);
    trig = 0; w = 1;
    while (pout && w < 100000) begin
      check(pout_n == !pout, "R2", pout_n, !pout);
      if (disturb && w == 1) begin trig = 1; code = ~code; co = ~co; end
      if (disturb && w == 2) trig = 0;
      if (disturb && w == 3) trig = 1;
      @(negedge clk);
      if (pout) w++;
    end
    trig = 0;
  endtask

  task automatic settle();
    trig = 0;
    while (pout) @(negedge clk);
    repeat (RECOV + 3) @(negedge clk);
  endtask

  task automatic probe(int j, bit expect_go);
    repeat (j) @(negedge clk);
    trig = 1;
    @(negedge clk);
    check(pout == expect_go, "R8", pout, expect_go);
    settle();
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(pout == 0 && pout_n == 1, "R2 reset", pout, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    fire(0, 0, 0, w);            check(w == INH, "R4", w, INH); settle();
    fire(0, 1, 0, w);            check(w == INH, "R4 coarse", w, INH); settle();
    fire(37, 0, 0, w);           check(w == exp_w(37, 0), "R3 fine", w, exp_w(37, 0)); settle();
    fire(64, 0, 0, w);           check(w == exp_w(64, 0), "R3 one unit", w, exp_w(64, 0)); settle();
    fire(63, 0, 0, w);           check(w == exp_w(63, 0), "R3 fine max", w, exp_w(63, 0)); settle();
    fire(3 * 64 + 17, 1, 0, w);  check(w == exp_w(3 * 64 + 17, 1), "R5", w, exp_w(3 * 64 + 17, 1)); settle();
    fire(63, 1, 0, w);           check(w == INH, "R5 fine ignored", w, INH); settle();
    fire(2 * 64 + 5, 0, 1, w);   check(w == exp_w(2 * 64 + 5, 0), "R6 R7", w, exp_w(2 * 64 + 5, 0)); settle();
    fire((1 << NW) - 1, 0, 0, w);
    check(w == INH + (1 << NW) - 1, "R10", w, INH + (1 << NW) - 1); settle();

    fire(10, 0, 0, w); probe(RECOV - 1, 0);
    fire(10, 0, 0, w); probe(RECOV, 1);

    // R9 kill mid-pulse
    @(negedge clk); code = NW'(200); co = 0; trig = 1;
    repeat (5) @(negedge clk);
    trig = 0; kill = 1;
    @(negedge clk);
    check(pout == 0, "R9 cut", pout, 0);
    trig = 1;
    repeat (3) @(negedge clk);
    check(pout == 0, "R9 held", pout, 0);
    trig = 0; kill = 0;
    probe(RECOV - 1, 0);
    @(negedge clk); trig = 1; kill = 1;
    @(negedge clk); kill = 0; trig = 0;
    probe(RECOV, 1);

    void'($urandom(32'h5eed));
    for (int i = 0; i < 40; i++) begin
      int c = $urandom % (1 << (FW + 3));
      bit m = $urandom % 2;
      bit d = $urandom % 2;
      fire(c, m, d, w);
      check(w == exp_w(c, m), m ? "R5 rand" : "R3 rand", w, exp_w(c, m));
      settle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule